// File: doc/BRIEF.md
# Multi-microphone PDM capture front end

This block drives the bit clock for a set of pulse-density-modulated microphones and turns their shared data lines back into one bit stream per logical channel. Two data lines come in, and each carries two microphones: one drives its bit for the half period ending at the rising clock edge, the other for the half period ending at the falling edge. The block samples both lines at both edges. Each logical channel then picks one line and one edge through its own routing bits, so any channel can listen to any of the four microphone slots.

The bit clock comes from an integer divider on the master clock, and the block always drives it. At the end of every bit period each enabled channel shows its new bit and a one-cycle valid strobe, which a downstream decimation filter consumes. A channel that is switched off stays silent at zero. A synchronous software reset puts the clock phase, the samples and the outputs back to their idle state. The divider setting is taken up only while every channel is off, so a running capture never sees its bit rate change.

Top module: `mic_pdm_front`

## Requirements
- R1: `pdm_clk` holds each level for H master-clock cycles, where H is the loaded divider value, and a divider value of 0 acts as 1.
- R2: The divider value on `div_cfg` is loaded on every master edge while `ch_en` is all zero. While any enable bit is set, the loaded value and so the half period stay unchanged.
- R3: Both data lines are sampled on the master edge where `pdm_clk` goes from 0 to 1 (rising-edge slot) and on the edge where it goes from 1 to 0 (falling-edge slot).
- R4: `edge_sel[n]` = 0 routes the rising-edge slot to channel n, and `edge_sel[n]` = 1 routes the falling-edge slot.
- R5: `line_sel[n]` = 0 routes `pdm_din[0]` to channel n, and `line_sel[n]` = 1 routes `pdm_din[1]`.
- R6: On the master edge where `pdm_clk` falls, every enabled channel updates `ch_bit[n]` and raises `ch_valid[n]` for exactly one cycle. `ch_bit[n]` holds between those edges.
- R7: A channel whose `ch_en[n]` is 0 produces no valid strobe, and its `ch_bit[n]` is 0 from the next master edge on.
- R8: A master edge with `soft_rst` high sets `pdm_clk` to 0, restarts the half-period count, and clears the samples, `ch_bit` and `ch_valid`. After the last such edge, `pdm_clk` first rises H edges later.
- R9: After `rst_n` is asserted, `pdm_clk`, `ch_bit` and `ch_valid` are 0 and the divider holds the default value `DEF_DIV`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset of the capture path |
| div_cfg | input | DIV_W | Half period of the bit clock in master cycles (0 acts as 1) |
| ch_en | input | NCH | Per-channel capture enable |
| edge_sel | input | NCH | Per-channel slot select: 0 rising, 1 falling |
| line_sel | input | NCH | Per-channel data line select: 0 line 0, 1 line 1 |
| pdm_din | input | 2 | The two shared microphone data lines |
| pdm_clk | output | 1 | Bit clock driven to the microphones |
| ch_bit | output | NCH | Recovered bit per channel |
| ch_valid | output | NCH | One-cycle strobe per channel, once per bit period |

## Verification
The checker covers the bit-clock rhythm on every cycle. It measures each half period against the divider setting and shows that the divider cannot move while a channel is enabled. It also ties the valid strobes to the falling edges of the bit clock and to the enables, keeps disabled channels at zero, and checks the idle state after a software reset. The routing of one line and one edge to each channel, and the value of every recovered bit, can be seen only in the bench. The bench drives known data into the rising and falling slots of both lines and compares all outputs on every cycle against a behavioural model.

// File: rtl/mic_pdm_pkg.sv
`timescale 1ns/1ps
package mic_pdm_pkg;
  localparam int NLINE = 2;

  // effective half period: a zero setting behaves like one
  function automatic int half_len(input int setting);
    return (setting == 0) ? 1 : setting;
  endfunction

  // slot choice for one channel: falling slot comes straight from the line,
  // rising slot from the value held since the last rising edge
  function automatic logic pick_sample(input logic [NLINE-1:0] rise_v,
                                       input logic [NLINE-1:0] line_v,
                                       input logic             line_pick,
                                       input logic             fall_pick);
    return fall_pick ? line_v[line_pick] : rise_v[line_pick];
  endfunction
endpackage

// File: rtl/mic_pdm_clkgen.sv
`timescale 1ns/1ps
module mic_pdm_clkgen #(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             pdm_clk,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic [DIV_W-1:0] div_q
);
  import mic_pdm_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             tick;

  assign tick     = int'(cnt_q) >= half_len(int'(div_q)) - 1;
  assign rise_evt = tick & ~clk_q;
  assign fall_evt = tick & clk_q;
  assign pdm_clk  = clk_q;

  // divider setting is frozen while capture runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= DIV_W'(DEF_DIV);
    else if (!hold) div_q <= div_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (soft_rst) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mic_pdm_sampler.sv
`timescale 1ns/1ps
module mic_pdm_sampler (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_rst,
  input  logic                         rise_evt,
  input  logic [mic_pdm_pkg::NLINE-1:0] pdm_din,
  output logic [mic_pdm_pkg::NLINE-1:0] rise_smp
);
  // rising-slot value of each line, held until the falling edge uses it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rise_smp <= '0;
    else if (soft_rst) rise_smp <= '0;
    else if (rise_evt) rise_smp <= pdm_din;
  end
endmodule

// File: rtl/mic_pdm_lane.sv
`timescale 1ns/1ps
module mic_pdm_lane (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_rst,
  input  logic                         en,
  input  logic                         fall_pick,
  input  logic                         line_pick,
  input  logic                         fall_evt,
  input  logic [mic_pdm_pkg::NLINE-1:0] rise_smp,
  input  logic [mic_pdm_pkg::NLINE-1:0] pdm_din,
  output logic                         bit_q,
  output logic                         valid_q
);
  import mic_pdm_pkg::*;

  logic sel_bit;
  assign sel_bit = pick_sample(rise_smp, pdm_din, line_pick, fall_pick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (soft_rst) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en & fall_evt;
      if (!en)           bit_q <= 1'b0;
      else if (fall_evt) bit_q <= sel_bit;
    end
  end
endmodule

// File: rtl/mic_pdm_front.sv
`timescale 1ns/1ps
module mic_pdm_front #(
  parameter int NCH     = 4,
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          soft_rst,
  input  logic [DIV_W-1:0]              div_cfg,
  input  logic [NCH-1:0]                ch_en,
  input  logic [NCH-1:0]                edge_sel,
  input  logic [NCH-1:0]                line_sel,
  input  logic [mic_pdm_pkg::NLINE-1:0] pdm_din,
  output logic                          pdm_clk,
  output logic [NCH-1:0]                ch_bit,
  output logic [NCH-1:0]                ch_valid
);
  import mic_pdm_pkg::*;

  // internal events, named for the checker
  logic                 rise_evt;
  logic                 fall_evt;
  logic                 any_on;
  logic [DIV_W-1:0]     div_q;
  logic [NLINE-1:0]     rise_smp;

  assign any_on = |ch_en;

  mic_pdm_clkgen #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .hold     (any_on),
    .div_cfg  (div_cfg),
    .pdm_clk  (pdm_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .div_q    (div_q)
  );

  mic_pdm_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .rise_evt (rise_evt),
    .pdm_din  (pdm_din),
    .rise_smp (rise_smp)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_lane
    mic_pdm_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .en        (ch_en[n]),
      .fall_pick (edge_sel[n]),
      .line_pick (line_sel[n]),
      .fall_evt  (fall_evt),
      .rise_smp  (rise_smp),
      .pdm_din   (pdm_din),
      .bit_q     (ch_bit[n]),
      .valid_q   (ch_valid[n])
    );
  end
endmodule

// File: rtl/mic_pdm_front_chk.sv
`timescale 1ns/1ps
module mic_pdm_front_chk #(
  parameter int NCH   = 4,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic [NCH-1:0]   ch_en,
  input logic             pdm_clk,
  input logic [NCH-1:0]   ch_bit,
  input logic [NCH-1:0]   ch_valid,
  input logic [DIV_W-1:0] div_q
);
  import mic_pdm_pkg::*;

  localparam int RUN_W = DIV_W + 1;

  logic             prev_clk;
  logic [DIV_W-1:0] prev_div;
  logic [RUN_W-1:0] run_len;
  logic             clean;
  logic             toggle_now;

  assign toggle_now = pdm_clk != prev_clk;

  // measures how long the bit clock held its previous level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      prev_div <= '0;
      run_len  <= '0;
      clean    <= 1'b0;
    end else begin
      prev_clk <= pdm_clk;
      prev_div <= div_q;
      if (toggle_now)         run_len <= RUN_W'(1);
      else if (~&run_len)     run_len <= run_len + 1'b1;
      if (soft_rst || div_q != prev_div) clean <= 1'b0;
      else if (toggle_now)               clean <= 1'b1;
    end
  end

  p_half_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_now && clean) |-> int'(run_len) == half_len(int'(prev_div)));

  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (|$past(ch_en))) |-> div_q == $past(div_q));

  p_valid_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_valid) |-> $fell(pdm_clk));

  p_fall_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pdm_clk) && $past(rst_n) && !$past(soft_rst)) |-> ch_valid == $past(ch_en));

  p_valid_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_valid) |-> (ch_valid & ~$past(ch_en)) == '0);

  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ch_bit & ~$past(ch_en)) == '0);

  p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (!pdm_clk && ch_bit == '0 && ch_valid == '0));
endmodule

bind mic_pdm_front mic_pdm_front_chk #(.NCH(NCH), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .ch_en    (ch_en),
  .pdm_clk  (pdm_clk),
  .ch_bit   (ch_bit),
  .ch_valid (ch_valid),
  .div_q    (div_q)
);

// File: tb/mic_pdm_front_test.sv
`timescale 1ns/1ps
module mic_pdm_front_test;
  localparam int NCH = 4;
  localparam int DIV_W = 8;
  localparam int DEF_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [DIV_W-1:0] div_cfg = 8'd3;
  logic [NCH-1:0] ch_en = '0, edge_sel = '0, line_sel = '0;
  logic [1:0] pdm_din = '0;
  logic pdm_clk;
  logic [NCH-1:0] ch_bit, ch_valid;

  always #2 clk = ~clk;

  mic_pdm_front #(.NCH(NCH), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .div_cfg(div_cfg),
    .ch_en(ch_en), .edge_sel(edge_sel), .line_sel(line_sel), .pdm_din(pdm_din),
    .pdm_clk(pdm_clk), .ch_bit(ch_bit), .ch_valid(ch_valid));

  int checks = 0, failures = 0;
  bit cmp_on = 0, done = 0, pat_mode = 0;
  localparam logic [1:0] PAT_RISE = 2'b01, PAT_FALL = 2'b11;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: counts, toggles and per-channel routing
  int m_cnt, m_div;
  bit m_clk;
  bit [1:0] m_rise;
  bit [NCH-1:0] m_bit, m_val;
  always @(posedge clk) begin
    int half;
    bit tk, r_ev, f_ev;
    bit [NCH-1:0] nb, nv;
    if (!rst_n) begin
      m_cnt = 0; m_clk = 0; m_div = DEF_DIV; m_rise = 0; m_bit = 0; m_val = 0;
    end else if (soft_rst) begin
      m_cnt = 0; m_clk = 0; m_rise = 0; m_bit = 0; m_val = 0;
      if (ch_en == 0) m_div = int'(div_cfg);
    end else begin
      half = (m_div == 0) ? 1 : m_div;
      tk = (m_cnt >= half - 1);
      r_ev = tk && !m_clk;
      f_ev = tk && m_clk;
      for (int n = 0; n < NCH; n++) begin
        nv[n] = ch_en[n] && f_ev;
        if (!ch_en[n]) nb[n] = 0;
        else if (f_ev) nb[n] = edge_sel[n] ? pdm_din[line_sel[n]] : m_rise[line_sel[n]];
        else nb[n] = m_bit[n];
      end
      m_bit = nb; m_val = nv;
      if (r_ev) m_rise = pdm_din;
      m_cnt = tk ? 0 : m_cnt + 1;
      if (tk) m_clk = !m_clk;
      if (ch_en == 0) m_div = int'(div_cfg);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(pdm_clk == m_clk, "R1 bit clock", int'(pdm_clk), int'(m_clk));
      chk(ch_valid == m_val, "R6 strobe", int'(ch_valid), int'(m_val));
      chk(ch_bit == m_bit, "R3 recovered bits", int'(ch_bit), int'(m_bit));
    end
    pdm_din <= pat_mode ? (pdm_clk ? PAT_FALL : PAT_RISE) : 2'($urandom);
  end

  task automatic wait_change();
    logic p;
    int n = 0;
    p = pdm_clk;
    do begin @(negedge clk); n++; end while (pdm_clk == p && n < 1000);
  endtask

  task automatic measure(output int h);
    logic p;
    int n = 0;
    wait_change();
    p = pdm_clk;
    do begin @(negedge clk); n++; end while (pdm_clk == p && n < 1000);
    h = n;
  endtask

  task automatic wait_all_valid();
    int n = 0;
    do begin @(negedge clk); n++; end while (ch_valid != ch_en && n < 500);
  endtask

  initial begin
    int h;
    repeat (5) @(negedge clk);
    chk(pdm_clk == 0 && ch_bit == 0 && ch_valid == 0, "R9 reset state",
        int'({pdm_clk, ch_bit, ch_valid}), 0);
    rst_n = 1'b1;
    cmp_on = 1;

    measure(h); chk(h == 3, "R1 half period 3", h, 3);
    div_cfg = 8'd0;
    wait_change();
    measure(h); chk(h == 1, "R1 zero divider acts as one", h, 1);
    div_cfg = 8'd3;
    wait_change(); wait_change();
    ch_en = 4'hF;
    @(negedge clk);
    div_cfg = 8'd6;
    measure(h); chk(h == 3, "R2 divider frozen while enabled", h, 3);
    measure(h); chk(h == 3, "R2 divider frozen while enabled", h, 3);
    ch_en = 4'h0;
    wait_change(); wait_change();
    measure(h); chk(h == 6, "R2 divider loaded while idle", h, 6);

    div_cfg = 8'd2;
    wait_change(); wait_change();
    for (int k = 0; k < 40; k++) begin
      ch_en = 4'($urandom); edge_sel = 4'($urandom); line_sel = 4'($urandom);
      repeat (50) @(negedge clk);
    end

    pat_mode = 1;
    ch_en = 4'hF; edge_sel = 4'b1010; line_sel = 4'b1100;
    wait_all_valid(); wait_all_valid();
    chk(ch_bit == 4'b1011, "R4 R5 routing set A", int'(ch_bit), 4'b1011);
    edge_sel = 4'b0101; line_sel = 4'b0011;
    wait_all_valid(); wait_all_valid();
    chk(ch_bit == 4'b1101, "R4 R5 routing set B", int'(ch_bit), 4'b1101);
    chk(ch_valid == 4'hF, "R6 strobe on all enabled", int'(ch_valid), 15);

    ch_en = 4'b1011;
    for (int k = 0; k < 3; k++) begin
      wait_all_valid();
      chk(ch_valid[2] == 0 && ch_bit[2] == 0, "R7 disabled channel silent",
          int'({ch_valid[2], ch_bit[2]}), 0);
    end

    ch_en = 4'h0; div_cfg = 8'd5;
    repeat (3) @(negedge clk);
    ch_en = 4'hF;
    begin
      int n = 0;
      while (pdm_clk != 1'b1 && n < 100) begin @(negedge clk); n++; end
    end
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(pdm_clk == 0 && ch_bit == 0 && ch_valid == 0, "R8 soft reset clears",
        int'({pdm_clk, ch_bit, ch_valid}), 0);
    begin
      int lows = 1;
      @(negedge clk);
      while (pdm_clk == 1'b0 && lows < 100) begin lows++; @(negedge clk); end
      chk(lows == 5, "R8 phase restarts", lows, 5);
    end
    repeat (100) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule